// File: doc/BRIEF.md
# Guarded Iterative GCD Unit

This block computes the greatest common divisor of two unsigned operands. It holds two working registers and takes one step per clock cycle. When the first register is larger than the second, the two values are exchanged. Otherwise the second register is reduced by the first. The computation ends when the second register reaches zero, and the first register then holds the answer.

The block has two interfaces, and both are guarded by the same idle condition: the second working register is zero. A caller raises `start_en` with the operands while `start_ready` is high. A new request is accepted only while no computation is running. The result is presented on `result_data` with `result_valid` high for as long as the block stays idle.

A build-time option selects a fused step. In the fused step the exchange and the following subtraction happen in a single cycle, which shortens the run. A busy-cycle counter shows how many cycles the most recent request took, so the plain and fused variants can be compared.

Top module: `gcd_unit`

## Requirements
- R1: After reset both working registers are zero. `start_ready` and `result_valid` are then high, `result_data` is 0 and `busy_cycles` is 0.
- R2: A start strobe with `start_ready` high loads the operands. If `start_b` is nonzero, `start_ready` and `result_valid` are low in the next cycle.
- R3: A start strobe raised while `start_ready` is low is ignored. The running computation keeps its operands, its result and its cycle count.
- R4: For nonzero operands, `result_valid` returns high and `result_data` then equals the greatest common divisor of `start_a` and `start_b`.
- R5: While idle with no start strobe, `result_data` and `result_valid` stay unchanged from cycle to cycle.
- R6: A start with `start_b` equal to zero completes at once. In the next cycle `result_valid` is high, `result_data` equals `start_a` and `busy_cycles` is 0.
- R7: `busy_cycles` clears on an accepted start and then increases by one for each cycle spent busy, saturating at its maximum. For operands 15 and 6 it ends at 6 in plain mode and at 4 in fused mode.
- R8: The fused variant gives the same result as the plain variant and never takes more busy cycles.
- R9: While busy, the larger of the two working values never increases from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_a | input | WIDTH | First operand, loaded into the result register |
| start_b | input | WIDTH | Second operand, loaded into the guard register |
| start_en | input | 1 | Start strobe; takes effect only while `start_ready` is high |
| start_ready | output | 1 | High while idle; a start may be accepted |
| result_data | output | WIDTH | Current result register value |
| result_valid | output | 1 | High while idle; `result_data` holds the result |
| busy_cycles | output | CNT_WIDTH | Busy cycles since the last accepted start |

## Verification
The assertion that the larger working value never grows assumes that the first operand is nonzero whenever the second one is. With a zero first operand and a nonzero second operand, the subtract step would repeat forever without changing anything. The stimulus uses only nonzero first operands. A zero second operand is used only in the directed immediate-completion case. The sweep covers every pair from 1 to 24 on a 6-bit build, feeding plain and fused instances the same inputs. Expected values come from a modulo-based Euclid computation in the bench, and the two instances' cycle counts are compared against each other.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

   typedef enum logic [1:0] {
      STEP_IDLE = 2'd0,
      STEP_SWAP = 2'd1,
      STEP_SUB  = 2'd2
   } gcd_step_e;

endpackage

// File: rtl/gcd_step_sel.sv
module gcd_step_sel
   import gcd_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] x_val,
   input  logic [WIDTH-1:0] y_val,
   output gcd_step_e        step
);

   logic y_zero;
   logic x_above;

   assign y_zero  = (y_val == '0);
   assign x_above = (x_val > y_val);

   always_comb begin
      if (y_zero)       step = STEP_IDLE;
      else if (x_above) step = STEP_SWAP;
      else              step = STEP_SUB;
   end

endmodule

// File: rtl/gcd_next_val.sv
module gcd_next_val
   import gcd_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter bit FUSED = 1'b0
) (
   input  logic [WIDTH-1:0] x_val,
   input  logic [WIDTH-1:0] y_val,
   input  gcd_step_e        step,
   output logic [WIDTH-1:0] x_nxt,
   output logic [WIDTH-1:0] y_nxt
);

   logic [WIDTH-1:0] y_minus_x;
   logic [WIDTH-1:0] swap_y;

   assign y_minus_x = y_val - x_val;

   generate
      if (FUSED) begin : g_fused
         assign swap_y = x_val - y_val;
      end else begin : g_plain
         assign swap_y = x_val;
      end
   endgenerate

   always_comb begin
      x_nxt = x_val;
      y_nxt = y_val;
      case (step)
         STEP_SWAP: begin
            x_nxt = y_val;
            y_nxt = swap_y;
         end
         STEP_SUB: begin
            y_nxt = y_minus_x;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/gcd_busy_count.sv
module gcd_busy_count #(
   parameter int CNT_WIDTH = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 busy,
   output logic [CNT_WIDTH-1:0] count
);

   localparam logic [CNT_WIDTH-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)                        count <= '0;
      else if (clear)                    count <= '0;
      else if (busy && count != CNT_MAX) count <= count + 1'b1;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !clear && count != CNT_MAX) |=> count == $past(count) + 1'b1) // R7
      else $error("busy counter did not advance");

endmodule

// File: rtl/gcd_unit.sv
module gcd_unit
   import gcd_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter bit FUSED     = 1'b0,
   parameter int CNT_WIDTH = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [WIDTH-1:0]     start_a,
   input  logic [WIDTH-1:0]     start_b,
   input  logic                 start_en,
   output logic                 start_ready,
   output logic [WIDTH-1:0]     result_data,
   output logic                 result_valid,
   output logic [CNT_WIDTH-1:0] busy_cycles
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("gcd_unit: WIDTH must be at least 2");
      end
      if (CNT_WIDTH < 1) begin : g_bad_cnt
         $error("gcd_unit: CNT_WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] x_q;
   logic [WIDTH-1:0] y_q;
   logic [WIDTH-1:0] x_nxt;
   logic [WIDTH-1:0] y_nxt;
   logic [WIDTH-1:0] big_val;
   gcd_step_e        step;
   logic             idle;
   logic             accept;

   assign idle   = (y_q == '0);
   assign accept = start_en && idle;

   gcd_step_sel #(.WIDTH(WIDTH)) u_step_sel (
      .x_val (x_q),
      .y_val (y_q),
      .step  (step)
   );

   gcd_next_val #(.WIDTH(WIDTH), .FUSED(FUSED)) u_next_val (
      .x_val (x_q),
      .y_val (y_q),
      .step  (step),
      .x_nxt (x_nxt),
      .y_nxt (y_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
      end else if (accept) begin
         x_q <= start_a;
         y_q <= start_b;
      end else if (step != STEP_IDLE) begin
         x_q <= x_nxt;
         y_q <= y_nxt;
      end
   end

   gcd_busy_count #(.CNT_WIDTH(CNT_WIDTH)) u_busy_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .busy  (!idle),
      .count (busy_cycles)
   );

   assign start_ready  = idle;
   assign result_valid = idle;
   assign result_data  = x_q;
   assign big_val      = (x_q > y_q) ? x_q : y_q;

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_en && start_ready && start_b != '0) |=> !start_ready) // R2
      else $error("accepted start did not make the unit busy");

   AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (start_en && start_ready) |=> result_data == $past(start_a)) // R2
      else $error("first operand not loaded");

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && !start_en) |=> (result_valid && $stable(result_data))) // R5
      else $error("idle result changed");

   AST_MAX_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> big_val <= $past(big_val)) // R9
      else $error("larger working value grew");

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (start_en && start_ready) |=> busy_cycles == '0) // R7
      else $error("counter not cleared by start");

endmodule

// File: tb/gcd_unit_bench.sv
module gcd_unit_bench;

   localparam int W  = 6;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  start_a = '0;
   logic [W-1:0]  start_b = '0;
   logic          start_en = 1'b0;
   logic          rdy_p, val_p, rdy_f, val_f;
   logic [W-1:0]  res_p, res_f;
   logic [CW-1:0] cyc_p, cyc_f;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   gcd_unit #(.WIDTH(W), .FUSED(1'b0), .CNT_WIDTH(CW)) u_gcd_unit (
      .clk(clk), .rst_n(rst_n), .start_a(start_a), .start_b(start_b),
      .start_en(start_en), .start_ready(rdy_p), .result_data(res_p),
      .result_valid(val_p), .busy_cycles(cyc_p));

   gcd_unit #(.WIDTH(W), .FUSED(1'b1), .CNT_WIDTH(CW)) u_gcd_unit_fused (
      .clk(clk), .rst_n(rst_n), .start_a(start_a), .start_b(start_b),
      .start_en(start_en), .start_ready(rdy_f), .result_data(res_f),
      .result_valid(val_f), .busy_cycles(cyc_f));

   function automatic int ref_gcd(int a, int b);
      int p = a;
      int q = b;
      while (q != 0) begin
         int t = p % q;
         p = q;
         q = t;
      end
      return p;
   endfunction

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_start(int a, int b);
      start_a  = W'(a);
      start_b  = W'(b);
      start_en = 1'b1;
      @(negedge clk);
      start_en = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!(val_p && val_f) && n < 300) begin
         @(negedge clk);
         n++;
      end
      check("R4", "completion within limit", int'(val_p && val_f), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1", "ready after reset", int'(rdy_p), 1);
      check("R1", "valid after reset", int'(val_p), 1);
      check("R1", "data after reset", int'(res_p), 0);
      check("R1", "cycles after reset", int'(cyc_p), 0);

      // R2 and R7: worked example 15, 6
      pulse_start(15, 6);
      check("R2", "ready low after start", int'(rdy_p), 0);
      check("R2", "valid low after start", int'(val_f), 0);
      wait_done();
      check("R4", "gcd(15,6) plain", int'(res_p), 3);
      check("R4", "gcd(15,6) fused", int'(res_f), 3);
      check("R7", "plain cycles 15,6", int'(cyc_p), 6);
      check("R7", "fused cycles 15,6", int'(cyc_f), 4);

      // R5 hold while idle
      repeat (5) @(negedge clk);
      check("R5", "result held", int'(res_p), 3);
      check("R5", "valid held", int'(val_p), 1);
      check("R5", "cycles held", int'(cyc_p), 6);

      // R3 start while busy is ignored
      pulse_start(15, 6);
      pulse_start(35, 14);
      wait_done();
      check("R3", "result keeps first operands", int'(res_p), 3);
      check("R3", "cycles keep first run", int'(cyc_p), 6);

      // R6 zero second operand
      pulse_start(9, 0);
      check("R6", "valid immediately", int'(val_p), 1);
      check("R6", "result equals a", int'(res_p), 9);
      check("R6", "no busy cycles", int'(cyc_p), 0);

      // R4 and R8 sweep
      for (int a = 1; a <= 24; a++) begin
         for (int b = 1; b <= 24; b++) begin
            pulse_start(a, b);
            wait_done();
            check("R4", $sformatf("plain gcd(%0d,%0d)", a, b), int'(res_p), ref_gcd(a, b));
            check("R8", $sformatf("fused gcd(%0d,%0d)", a, b), int'(res_f), ref_gcd(a, b));
            check("R8", $sformatf("fused not slower (%0d,%0d)", a, b),
                  int'(cyc_f <= cyc_p), 1);
         end
      end

      // R7 largest operand pair on the plain build: 1 then 63
      pulse_start(1, 63);
      wait_done();
      check("R7", "plain cycles 1,63", int'(cyc_p), 63);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule